// File: doc/BRIEF.md
# LED Fault Blink-Code Generator

This block shows a small numeric code on a status LED as a flash pattern that a person can read off a board without a console. A second, fault LED frames the pattern so that the start and end of each showing can be seen. A status word comes in with a strobe. Positive values are kept quietly as the last good progress code. A zero or negative value starts the display, which repeats a fixed number of times and then raises a one-cycle reset request.

The stored code is split into base-`RADIX` digits, with the most significant digit first. A zero digit is one long flash. A nonzero digit N is N short flashes. Each digit ends with a long dark pause. Every repetition ends with a run of fault-LED blinks. All durations are counts of a tick enable (1 ms in the intended system), so the same logic works at any core clock. The default parameters give 3 base-5 digits, flashes of 1000 ms and 100 ms, 200 ms gaps, a further 700 ms pause after each digit, 5 repetitions and 5 frame blinks of 500 ms dark and 500 ms lit.

Top module: `blink_code_gen`

## Requirements
- R1: After reset, `code_led`, `fault_led` and `reset_req` are low and the stored code is 0, so a later status of 0 shows the all-zero pattern.
- R2: An accepted status greater than zero replaces the stored code with its low `CODE_W` bits. It lights no LED and raises no reset request.
- R3: An accepted status below -1 stores the low `CODE_W` bits of its two's-complement negation and starts a display of that value. A status of 0 or -1 starts a display of the stored code without changing it. The display begins in the cycle after the strobe is accepted.
- R4: The code is shown as `N_DIGIT` digits, most significant first. Digit k (k=0 least significant) is floor(code / RADIX^k) mod RADIX, so codes at or above RADIX^N_DIGIT wrap.
- R5: A zero digit is `code_led` high for `T_LONG` ticks, then low for `T_GAP` ticks. A nonzero digit N is N repeats of high for `T_SHORT` ticks and low for `T_GAP` ticks. Every digit is then followed by a further `T_PAUSE` ticks low.
- R6: The digit sequence is shown `N_REPEAT` times. `fault_led` is high from the first flash of each repetition through its last digit pause.
- R7: After each repetition's digits, `fault_led` blinks `N_BLINK` times, each blink being `T_HALF` ticks low and then `T_HALF` ticks high, while `code_led` stays low.
- R8: In the cycle after the last frame blink of the last repetition ends, `reset_req` is high for exactly one cycle, both LEDs are low, and the block is idle again.
- R9: Every duration advances only on cycles with `tick` high. With `tick` held low, the outputs hold their values.
- R10: A strobe that arrives while a display runs is ignored. It neither changes the stored code nor restarts the display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base enable, one cycle per tick |
| status_vld | input | 1 | Strobe qualifying `status_val` |
| status_val | input | STAT_W | Signed status or fault value |
| code_led | output | 1 | Digit flash drive, active high |
| fault_led | output | 1 | Framing fault LED drive, active high |
| reset_req | output | 1 | One-cycle request raised when the display finishes |

## Verification
The bench goes after digit patterns that separate the zero-digit dash from a counted flash run: all-zero codes, codes with inner zeros, the largest digit and a code that wraps past the digit range. A design that mixed up digit order, miscounted flashes by one or dropped the extra pause would misplace a whole segment in the expected LED stream. Negation is driven with a status whose magnitude overflows `CODE_W`, which catches sign or truncation errors. Strobes injected in the middle of a display, a stalled tick and a reset in mid-display expose designs that restart, store late values, run on the clock instead of the tick, or keep a stale code across reset.

// File: rtl/blink_code_pkg.sv
package blink_code_pkg;

   // Sequencer phases: one flash mark, the gap after it, the pause after a
   // digit, and the two halves of a framing blink.
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_MARK      = 3'd1,
      ST_SPACE     = 3'd2,
      ST_DWELL     = 3'd3,
      ST_FRM_DARK  = 3'd4,
      ST_FRM_LIT   = 3'd5
   } blink_state_e;

   function automatic int unsigned max_of2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned bits_for(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/blink_tick_timer.sv
module blink_tick_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // A segment loaded with D-1 ends on its D-th tick.
   assign expired = tick && (cnt_q == '0);

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(cnt_q)); // R9

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/blink_digit_split.sv
module blink_digit_split #(
   parameter int unsigned CODE_W  = 8,
   parameter int unsigned RADIX   = 5,
   parameter int unsigned N_DIGIT = 3,
   parameter int unsigned DIG_W   = 3
) (
   input  logic [CODE_W-1:0]              code,
   output logic [N_DIGIT-1:0][DIG_W-1:0]  digits
);

   generate
      if (RADIX < 2) begin : g_bad_radix
         $error("blink_digit_split: RADIX must be at least 2");
      end
      if (CODE_W > 31) begin : g_bad_code_w
         $error("blink_digit_split: CODE_W must be below 32");
      end

      for (genvar gi = 0; gi < N_DIGIT; gi++) begin : g_digit
         localparam int unsigned DIVISOR = RADIX ** gi;
         logic [31:0] quo;
         logic [31:0] rem;
         assign quo = 32'(code) / 32'(DIVISOR);
         assign rem = quo % 32'(RADIX);
         assign digits[gi] = DIG_W'(rem);
      end
   endgenerate

endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer
   import blink_code_pkg::*;
#(
   parameter int unsigned N_DIGIT  = 3,
   parameter int unsigned DIG_W    = 3,
   parameter int unsigned N_REPEAT = 5,
   parameter int unsigned N_BLINK  = 5,
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned T_LONG   = 1000,
   parameter int unsigned T_SHORT  = 100,
   parameter int unsigned T_GAP    = 200,
   parameter int unsigned T_PAUSE  = 700,
   parameter int unsigned T_HALF   = 500
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [N_DIGIT-1:0][DIG_W-1:0]  digits,
   input  logic                           seg_done,
   output logic                           load,
   output logic [CNT_W-1:0]               load_val,
   output logic                           busy,
   output logic                           code_led,
   output logic                           fault_led,
   output logic                           reset_req
);

   localparam int unsigned IDX_W = bits_for(N_DIGIT);
   localparam int unsigned REP_W = bits_for(N_REPEAT);
   localparam int unsigned BLK_W = bits_for(N_BLINK);

   localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(N_DIGIT - 1);
   localparam logic [REP_W-1:0] LAST_REP = REP_W'(N_REPEAT - 1);
   localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(N_BLINK - 1);

   // Timer load values are duration minus one.
   localparam logic [CNT_W-1:0] LD_LONG  = CNT_W'(T_LONG - 1);
   localparam logic [CNT_W-1:0] LD_SHORT = CNT_W'(T_SHORT - 1);
   localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(T_GAP - 1);
   localparam logic [CNT_W-1:0] LD_PAUSE = CNT_W'(T_PAUSE - 1);
   localparam logic [CNT_W-1:0] LD_HALF  = CNT_W'(T_HALF - 1);

   blink_state_e     st_q, st_n;
   logic [IDX_W-1:0] idx_q, idx_n;
   logic [DIG_W-1:0] pls_q, pls_n;
   logic [REP_W-1:0] rep_q, rep_n;
   logic [BLK_W-1:0] blk_q, blk_n;
   logic             rr_q, rr_n;

   logic [DIG_W-1:0] cur_dig;
   logic [DIG_W-1:0] nxt_dig;
   logic [DIG_W-1:0] top_dig;
   logic [IDX_W-1:0] idx_dn;
   logic [DIG_W:0]   pls_inc;
   logic             more_pulses;

   assign idx_dn      = (idx_q == '0) ? '0 : idx_q - 1'b1;
   assign cur_dig     = digits[idx_q];
   assign nxt_dig     = digits[idx_dn];
   assign top_dig     = digits[TOP_IDX];
   assign pls_inc     = {1'b0, pls_q} + {{DIG_W{1'b0}}, 1'b1};
   assign more_pulses = (cur_dig != '0) && (pls_inc < {1'b0, cur_dig});

   function automatic logic [CNT_W-1:0] mark_len(logic [DIG_W-1:0] d);
      return (d == '0) ? LD_LONG : LD_SHORT;
   endfunction

   always_comb begin
      st_n     = st_q;
      idx_n    = idx_q;
      pls_n    = pls_q;
      rep_n    = rep_q;
      blk_n    = blk_q;
      rr_n     = 1'b0;
      load     = 1'b0;
      load_val = '0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_n     = ST_MARK;
               idx_n    = TOP_IDX;
               pls_n    = '0;
               rep_n    = '0;
               load     = 1'b1;
               load_val = mark_len(top_dig);
            end
         end
         ST_MARK: begin
            if (seg_done) begin
               st_n     = ST_SPACE;
               load     = 1'b1;
               load_val = LD_GAP;
            end
         end
         ST_SPACE: begin
            if (seg_done) begin
               load = 1'b1;
               if (more_pulses) begin
                  st_n     = ST_MARK;
                  pls_n    = pls_q + 1'b1;
                  load_val = LD_SHORT;
               end else begin
                  st_n     = ST_DWELL;
                  load_val = LD_PAUSE;
               end
            end
         end
         ST_DWELL: begin
            if (seg_done) begin
               load = 1'b1;
               if (idx_q != '0) begin
                  st_n     = ST_MARK;
                  idx_n    = idx_dn;
                  pls_n    = '0;
                  load_val = mark_len(nxt_dig);
               end else begin
                  st_n     = ST_FRM_DARK;
                  blk_n    = '0;
                  load_val = LD_HALF;
               end
            end
         end
         ST_FRM_DARK: begin
            if (seg_done) begin
               st_n     = ST_FRM_LIT;
               load     = 1'b1;
               load_val = LD_HALF;
            end
         end
         ST_FRM_LIT: begin
            if (seg_done) begin
               if (blk_q != LAST_BLK) begin
                  st_n     = ST_FRM_DARK;
                  blk_n    = blk_q + 1'b1;
                  load     = 1'b1;
                  load_val = LD_HALF;
               end else if (rep_q != LAST_REP) begin
                  st_n     = ST_MARK;
                  rep_n    = rep_q + 1'b1;
                  idx_n    = TOP_IDX;
                  pls_n    = '0;
                  load     = 1'b1;
                  load_val = mark_len(top_dig);
               end else begin
                  st_n = ST_IDLE;
                  rr_n = 1'b1;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
         pls_q <= '0;
         rep_q <= '0;
         blk_q <= '0;
         rr_q  <= 1'b0;
      end else begin
         st_q  <= st_n;
         idx_q <= idx_n;
         pls_q <= pls_n;
         rep_q <= rep_n;
         blk_q <= blk_n;
         rr_q  <= rr_n;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign code_led  = (st_q == ST_MARK);
   assign fault_led = (st_q == ST_MARK) || (st_q == ST_SPACE) ||
                      (st_q == ST_DWELL) || (st_q == ST_FRM_LIT);
   assign reset_req = rr_q;

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req); // R8

   AST_REQ_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_req) |-> ($past(st_q) == ST_FRM_LIT) && !busy); // R8

   AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_MARK && cur_dig != '0) |-> ({1'b0, pls_q} < {1'b0, cur_dig})); // R5

   AST_FRAME_DARK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FRM_DARK || st_q == ST_FRM_LIT) |-> !code_led); // R7

endmodule

// File: rtl/blink_code_gen.sv
module blink_code_gen
   import blink_code_pkg::*;
#(
   parameter int unsigned STAT_W   = 16,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned RADIX    = 5,
   parameter int unsigned N_DIGIT  = 3,
   parameter int unsigned N_REPEAT = 5,
   parameter int unsigned N_BLINK  = 5,
   parameter int unsigned T_LONG   = 1000,
   parameter int unsigned T_SHORT  = 100,
   parameter int unsigned T_GAP    = 200,
   parameter int unsigned T_PAUSE  = 700,
   parameter int unsigned T_HALF   = 500
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     status_vld,
   input  logic signed [STAT_W-1:0] status_val,
   output logic                     code_led,
   output logic                     fault_led,
   output logic                     reset_req
);

   localparam int unsigned DIG_W   = bits_for(RADIX);
   localparam int unsigned DUR_MAX = max_of2(max_of2(max_of2(T_LONG, T_SHORT),
                                              max_of2(T_GAP, T_PAUSE)), T_HALF);
   localparam int unsigned CNT_W   = bits_for(DUR_MAX);

   generate
      if (T_LONG < 1 || T_SHORT < 1 || T_GAP < 1 || T_PAUSE < 1 || T_HALF < 1)
      begin : g_bad_dur
         $error("blink_code_gen: every duration must be at least one tick");
      end
      if (N_DIGIT < 1 || N_REPEAT < 1 || N_BLINK < 1) begin : g_bad_count
         $error("blink_code_gen: digit, repeat and blink counts must be positive");
      end
      if (CODE_W > STAT_W || STAT_W < 2) begin : g_bad_width
         $error("blink_code_gen: CODE_W must not exceed STAT_W");
      end
   endgenerate

   logic [CODE_W-1:0]              code_q;
   logic [CODE_W-1:0]              code_nxt;
   logic [N_DIGIT-1:0][DIG_W-1:0]  digits;
   logic                           busy;
   logic                           accept;
   logic                           is_pos;
   logic                           is_big_neg;
   logic                           start;
   logic                           seg_done;
   logic                           tmr_load;
   logic [CNT_W-1:0]               tmr_val;

   assign accept     = status_vld && !busy;
   assign is_pos     = (status_val > 0);
   assign is_big_neg = (status_val < -1);
   assign start      = accept && !is_pos;

   always_comb begin
      code_nxt = code_q;
      if (accept && is_pos) begin
         code_nxt = CODE_W'(status_val);
      end else if (accept && is_big_neg) begin
         code_nxt = CODE_W'(-status_val);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
      end else begin
         code_q <= code_nxt;
      end
   end

   // Digits follow the next code so a fresh negative status shows at once.
   blink_digit_split #(
      .CODE_W  (CODE_W),
      .RADIX   (RADIX),
      .N_DIGIT (N_DIGIT),
      .DIG_W   (DIG_W)
   ) u_split (
      .code   (code_nxt),
      .digits (digits)
   );

   blink_tick_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (seg_done)
   );

   blink_sequencer #(
      .N_DIGIT  (N_DIGIT),
      .DIG_W    (DIG_W),
      .N_REPEAT (N_REPEAT),
      .N_BLINK  (N_BLINK),
      .CNT_W    (CNT_W),
      .T_LONG   (T_LONG),
      .T_SHORT  (T_SHORT),
      .T_GAP    (T_GAP),
      .T_PAUSE  (T_PAUSE),
      .T_HALF   (T_HALF)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .digits    (digits),
      .seg_done  (seg_done),
      .load      (tmr_load),
      .load_val  (tmr_val),
      .busy      (busy),
      .code_led  (code_led),
      .fault_led (fault_led),
      .reset_req (reset_req)
   );

   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(code_q)); // R10

   AST_POS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (status_vld && !busy && status_val > 0) |=> !busy && !code_led); // R2

   AST_NEG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (status_vld && !busy && status_val <= 0) |=> busy && fault_led); // R3

endmodule

// File: tb/blink_code_gen_tb.sv
module blink_code_gen_tb;

   localparam int STAT_W  = 16;
   localparam int CODE_W  = 8;
   localparam int RADIX   = 5;
   localparam int NDIG    = 3;
   localparam int NREP    = 5;
   localparam int NBLK    = 5;
   localparam int TLONG   = 6;
   localparam int TSHORT  = 2;
   localparam int TGAP    = 3;
   localparam int TPAUSE  = 4;
   localparam int THALF   = 3;

   localparam int NVEC = 8;
   // status driven, and the code expected on the LED (-1: no display)
   localparam int TV_STAT [NVEC] = '{37, 0, -1, -50, 125, 0, -3, -300};
   localparam int TV_SHOW [NVEC] = '{-1, 37, 37, 50, -1, 125, 3, 44};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic status_vld = 1'b0;
   logic signed [STAT_W-1:0] status_val = '0;
   logic code_led, fault_led, reset_req;

   int n_chk  = 0;
   int n_fail = 0;

   logic sc [0:255];
   logic sf [0:255];
   int   sl [0:255];
   string stag [0:255];
   int   nseg;

   always #10 clk = ~clk;

   blink_code_gen #(
      .STAT_W (STAT_W), .CODE_W (CODE_W), .RADIX (RADIX), .N_DIGIT (NDIG),
      .N_REPEAT (NREP), .N_BLINK (NBLK), .T_LONG (TLONG), .T_SHORT (TSHORT),
      .T_GAP (TGAP), .T_PAUSE (TPAUSE), .T_HALF (THALF)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .tick (tick), .status_vld (status_vld),
      .status_val (status_val), .code_led (code_led), .fault_led (fault_led),
      .reset_req (reset_req)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic add_seg(logic c, logic f, int len, string tg);
      sc[nseg] = c; sf[nseg] = f; sl[nseg] = len; stag[nseg] = tg;
      nseg++;
   endtask

   // Expected LED stream built from the requirement text.
   task automatic build(int code);
      nseg = 0;
      for (int r = 0; r < NREP; r++) begin
         for (int d = NDIG - 1; d >= 0; d--) begin
            int pw = 1;
            int dg;
            for (int k = 0; k < d; k++) pw = pw * RADIX;
            dg = (code / pw) % RADIX;
            if (dg == 0) begin
               add_seg(1'b1, 1'b1, TLONG, "R5 zero-digit dash (R4 order)");
               add_seg(1'b0, 1'b1, TGAP, "R5 gap");
            end else begin
               for (int p = 0; p < dg; p++) begin
                  add_seg(1'b1, 1'b1, TSHORT, "R5 short flash (R4 order)");
                  add_seg(1'b0, 1'b1, TGAP, "R5 gap");
               end
            end
            add_seg(1'b0, 1'b1, TPAUSE, "R5 digit pause, R6 fault lit");
         end
         for (int b = 0; b < NBLK; b++) begin
            add_seg(1'b0, 1'b0, THALF, "R7 frame dark");
            add_seg(1'b0, 1'b1, THALF, "R7 frame lit");
         end
      end
   endtask

   task automatic send(int v);
      @(negedge clk);
      status_val = STAT_W'(v);
      status_vld = 1'b1;
      @(negedge clk);
      status_vld = 1'b0;
   endtask

   // Called at the negedge of the first display cycle.
   task automatic check_display(int code, int inj_at, int inj_val);
      int cyc = 0;
      build(code);
      for (int s = 0; s < nseg; s++) begin
         bit ok = 1'b1;
         int act = 0;
         for (int k = 0; k < sl[s]; k++) begin
            if (cyc == inj_at) begin
               status_val = STAT_W'(inj_val);
               status_vld = 1'b1;
            end else begin
               status_vld = 1'b0;
            end
            if (ok && (code_led !== sc[s] || fault_led !== sf[s] || reset_req !== 1'b0)) begin
               ok = 1'b0;
               act = {code_led, fault_led, reset_req};
            end
            @(negedge clk);
            cyc++;
         end
         chk(ok, stag[s], $sformatf("code %0d seg %0d {code,fault,req}", code, s),
             act, {sc[s], sf[s], 1'b0});
      end
      status_vld = 1'b0;
      chk(reset_req === 1'b1 && code_led === 1'b0 && fault_led === 1'b0, "R8",
          "end pulse {code,fault,req}", {code_led, fault_led, reset_req}, 1);
      @(negedge clk);
      chk(reset_req === 1'b0, "R8", "pulse width", reset_req, 0);
   endtask

   task automatic check_quiet(string req, int cycles);
      bit ok = 1'b1;
      int act = 0;
      for (int k = 0; k < cycles; k++) begin
         if (ok && (code_led !== 1'b0 || fault_led !== 1'b0 || reset_req !== 1'b0)) begin
            ok = 1'b0;
            act = {code_led, fault_led, reset_req};
         end
         @(negedge clk);
      end
      chk(ok, req, "idle {code,fault,req}", act, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(code_led === 1'b0 && fault_led === 1'b0 && reset_req === 1'b0, "R1",
          "reset outputs", {code_led, fault_led, reset_req}, 0);
      rst_n = 1'b1;
      check_quiet("R1", 5);

      // Table walk
      for (int v = 0; v < NVEC; v++) begin
         send(TV_STAT[v]);
         if (TV_SHOW[v] < 0) check_quiet("R2", 20);
         else check_display(TV_SHOW[v], -1, 0);
      end

      // R9: stalled tick freezes the first long dash of code 20 (0,4,0)
      tick = 1'b0;
      send(-20);
      begin
         bit ok = 1'b1;
         for (int k = 0; k < 25; k++) begin
            if (code_led !== 1'b1 || fault_led !== 1'b1) ok = 1'b0;
            @(negedge clk);
         end
         chk(ok, "R9", "held dash without tick", {code_led, fault_led}, 3);
      end
      tick = 1'b1;
      check_display(20, -1, 0);

      // R10: strobes during a display are ignored
      send(0);
      check_display(20, 15, 99);
      send(-1);
      check_display(20, 40, -7);
      send(0);
      check_display(20, -1, 0);

      // R1: reset in mid-display darkens outputs and clears the code
      send(-9);
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(code_led === 1'b0 && fault_led === 1'b0 && reset_req === 1'b0, "R1",
          "mid-display reset", {code_led, fault_led, reset_req}, 0);
      rst_n = 1'b1;
      send(0);
      check_display(0, -1, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule